// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a clocked single-port static memory with byte-granular writes and a four-beat wraparound burst. Every rising clock edge is classified from the chip selects, two address strobes (one for a processor, one for a controller), an advance input, the write enables and a sleep input. The outcome is one of seven cycle kinds: idle, deselect, sleep, read start, write start, read continue or write continue. The shared data bus is split into a write-data input, a read-data output and a drive-enable output, so no internal tri-state is needed. A board-level wrapper combines them into a bidirectional pin.

A strobe cycle loads the full word address. Later cycles without a strobe continue the burst. The two low address bits step through a linear or interleaved order, chosen by `lin_mode`, and the upper bits stay fixed. Read data is registered, so it appears one cycle after the edge that samples the address. The drive enable also depends on the output-enable pin, which is not clocked. The sleep input passes through two flops. Entering and leaving sleep therefore each take two edges, and the array contents are kept while the block sleeps.

All pins are plain level-sampled control and data. There is no valid/ready flow control, and the block never applies back-pressure: a request made at an edge is either carried out in that cycle or dropped.

Top module: `sbsram_core`

## Requirements
- R1: With `gw_n` low, a write cycle updates every byte of the addressed word with `din`.
- R2: With `gw_n` high and `bwe_n` low, a write updates only the bytes whose `bw_n` bit is low (bit i selects `din[8i+7:8i]`). The other bytes keep their old contents.
- R3: When `gw_n` is high and either `bwe_n` is high or all `bw_n` bits are high, no write happens. A controller-strobe cycle then becomes a read start of the given address.
- R4: A selected, non-sleeping cycle with `adsp_n` low is always a read start, whatever `gw_n`, `bwe_n` and `bw_n` are.
- R5: The word read at a clock edge appears on `dout`, with `dout_en` high, from that edge until the next edge.
- R6: `dout_en` is high only while `oe_n` is low, and it follows `oe_n` without waiting for a clock. After a write cycle, `dout_en` is low.
- R7: A strobe cycle with `cs_n` high or `cs2` low is a deselect. It ends any burst, makes no access, and `dout_en` is low afterwards. Later continue cycles do nothing until the next strobe.
- R8: With `lin_mode` = 1, the k-th advance of a burst started at address A accesses address A with its low two bits replaced by (A[1:0] + k) mod 4.
- R9: With `lin_mode` = 0, the k-th advance accesses address A with its low two bits replaced by A[1:0] XOR k.
- R10: A continue cycle with `adv_n` high accesses the same address again.
- R11: After `sleep` rises, two more edges still operate and the third edge is asleep. After `sleep` falls, two more edges stay asleep and the third edge operates. While asleep, no read or write happens and `dout_en` is low. Stored words survive sleep.
- R12: The chip selects are ignored in cycles with no strobe, so a running burst continues even when `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| cs_n | input | 1 | Primary chip select, active low |
| cs2 | input | 1 | Secondary chip select, active high |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | NB | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Sleep request, asynchronous, active high |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address sampled on strobe cycles |
| din | input | NB*8 | Write data |
| dout | output | NB*8 | Registered read data |
| dout_en | output | 1 | Drive enable for the data pins |

## Verification
The embedded properties assume that `lin_mode` is held constant for the whole of a burst, and that reset is released only after the first clock edge. They also assume that a write cycle and a read are never requested at the same edge, which the cycle decoder ensures. The stimulus changes `lin_mode` only between bursts, and it drives every input on the falling clock edge, so each rising edge sees settled values. It also writes each address before that address is read back, so every data comparison is against a value the bench model knows.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_SLEEP,
    CYC_RD_START,
    CYC_WR_START,
    CYC_RD_CONT,
    CYC_WR_CONT
  } cyc_e;

  localparam int BYTE_W = 8;
  localparam int BURST_OW = 2;
endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr #(
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [OW-1:0] start,
  input  logic          step,
  input  logic          lin,
  output logic [OW-1:0] ofs,
  output logic [OW-1:0] ofs_nxt
);
  logic [OW-1:0] st_q;
  logic [OW-1:0] cnt_q;
  logic [OW-1:0] cnt_p1;

  assign cnt_p1  = cnt_q + OW'(1);
  assign ofs     = lin ? (st_q + cnt_q)  : (st_q ^ cnt_q);
  assign ofs_nxt = lin ? (st_q + cnt_p1) : (st_q ^ cnt_p1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      st_q  <= start;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_p1;
    end
  end

  // R8
  load_starts_at_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ofs == $past(start)));

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && lin) |=> (!lin || ofs == $past(ofs) + OW'(1)));
endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          asleep,
  input  logic          active,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          cs_n,
  input  logic          cs2,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  output cyc_e          cyc,
  output logic [NB-1:0] wmask,
  output logic          do_step
);
  logic wr_req;
  logic strobe;
  logic unsel;

  assign wr_req = !gw_n || (!bwe_n && !(&bw_n));
  assign strobe = !adsp_n || !adsc_n;
  assign unsel  = cs_n || !cs2;

  always_comb begin
    if (!gw_n)       wmask = '1;
    else if (!bwe_n) wmask = ~bw_n;
    else             wmask = '0;
  end

  always_comb begin
    if (asleep)            cyc = CYC_SLEEP;
    else if (strobe) begin
      if (unsel)           cyc = CYC_DESEL;
      else if (!adsp_n)    cyc = CYC_RD_START;
      else if (wr_req)     cyc = CYC_WR_START;
      else                 cyc = CYC_RD_START;
    end
    else if (active)       cyc = wr_req ? CYC_WR_CONT : CYC_RD_CONT;
    else                   cyc = CYC_IDLE;
  end

  assign do_step = !adv_n && (cyc == CYC_RD_CONT || cyc == CYC_WR_CONT);

  // R4
  proc_strobe_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !adsp_n && !cs_n && cs2) |-> (cyc == CYC_RD_START));

  // R3
  no_write_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && (bwe_n || &bw_n)) |-> (cyc != CYC_WR_START && cyc != CYC_WR_CONT));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic               re,
  input  logic [NB-1:0]      wmask,
  input  logic [AW-1:0]      addr,
  input  logic [NB*BYTE_W-1:0] wdata,
  output logic [NB*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[b]) lane_mem[addr] <= wdata[b*BYTE_W +: BYTE_W];
      if (re)             rdata[b*BYTE_W +: BYTE_W] <= lane_mem[addr];
    end
  end

  // R6
  single_op_chk: assert property (@(posedge clk) !(we && re));
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               cs2,
  input  logic               adsp_n,
  input  logic               adsc_n,
  input  logic               adv_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [NB-1:0]      bw_n,
  input  logic               oe_n,
  input  logic               sleep,
  input  logic               lin_mode,
  input  logic [AW-1:0]      addr,
  input  logic [NB*8-1:0]    din,
  output logic [NB*8-1:0]    dout,
  output logic               dout_en
);
  localparam int OW = BURST_OW;
  localparam int HW = AW - OW;

  logic          slp_s1, slp_q;
  logic          active;
  logic [HW-1:0] base_hi;
  cyc_e          cyc;
  logic [NB-1:0] wmask;
  logic          do_step;
  logic [OW-1:0] ofs, ofs_nxt;
  logic          is_start, is_cont;
  logic [AW-1:0] acc_addr;
  logic          mem_we, mem_re;
  logic          rd_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_s1 <= 1'b0;
      slp_q  <= 1'b0;
    end else begin
      slp_s1 <= sleep;
      slp_q  <= slp_s1;
    end
  end

  sbsram_decode #(.NB(NB)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .asleep  (slp_q),
    .active  (active),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .cs_n    (cs_n),
    .cs2     (cs2),
    .adv_n   (adv_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .cyc     (cyc),
    .wmask   (wmask),
    .do_step (do_step)
  );

  assign is_start = (cyc == CYC_RD_START) || (cyc == CYC_WR_START);
  assign is_cont  = (cyc == CYC_RD_CONT)  || (cyc == CYC_WR_CONT);
  assign mem_we   = (cyc == CYC_WR_START) || (cyc == CYC_WR_CONT);
  assign mem_re   = (cyc == CYC_RD_START) || (cyc == CYC_RD_CONT);

  sbsram_burst_ctr #(.OW(OW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (is_start),
    .start   (addr[OW-1:0]),
    .step    (do_step),
    .lin     (lin_mode),
    .ofs     (ofs),
    .ofs_nxt (ofs_nxt)
  );

  always_comb begin
    if (is_cont) acc_addr = {base_hi, (adv_n ? ofs : ofs_nxt)};
    else         acc_addr = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base_hi <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= mem_re;
      if (is_start) begin
        active  <= 1'b1;
        base_hi <= addr[AW-1:OW];
      end else if (cyc == CYC_DESEL || cyc == CYC_SLEEP) begin
        active  <= 1'b0;
      end
    end
  end

  sbsram_array #(.AW(AW), .NB(NB)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .wmask (wmask),
    .addr  (acc_addr),
    .wdata (din),
    .rdata (dout)
  );

  assign dout_en = rd_vld && !oe_n;

  // R6
  write_quiets_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !dout_en);

  // R7
  deselect_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |=> (!dout_en && !active));

  // R11
  sleep_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slp_q |-> (!mem_we && !mem_re));

  // R11
  sleep_drops_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slp_q |=> !active);
endmodule

// File: tb/sbsram_core_test.sv
`timescale 1ns/1ps
module sbsram_core_test;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n, cs2, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, sleep, lin_mode;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sbsram_core #(.AW(AW), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs2(cs2), .adsp_n(adsp_n),
    .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .oe_n(oe_n), .sleep(sleep), .lin_mode(lin_mode), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cs_n = 1'b0; cs2 = 1'b1; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; din = '0;
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout_en actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_data(input string req, input logic [DW-1:0] exp);
    checks++;
    if (dout_en !== 1'b1 || dout !== exp) begin
      fails++;
      $display("FAIL %s: dout actual=%h (en=%0b) expected=%h", req, dout, dout_en, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nw,
                                          input logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] s, input int k,
                                          input logic lin);
    logic [1:0] lo = lin ? 2'(s[1:0] + k) : (s[1:0] ^ 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  // Full write through the controller strobe (R1)
  task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle_inputs(); adsc_n = 1'b0; gw_n = 1'b0; addr = a; din = d;
    tick();
    model[a] = d;
    chk_bit("R6", dout_en, 1'b0);
    idle_inputs();
  endtask

  // Processor-strobe read start with writes requested (R4, R5)
  task automatic rd_proc(input logic [AW-1:0] a, input string req);
    idle_inputs(); adsp_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = '0;
    addr = a; din = ~model[a];
    tick();
    chk_data(req, model[a]);
    idle_inputs();
  endtask

  initial begin : watchdog
    #(150000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    idle_inputs(); oe_n = 1'b0; sleep = 1'b0; lin_mode = 1'b1; addr = '0;
    tick();
    chk_bit("R5", dout_en, 1'b0);
    rst_n = 1'b1;
    tick();
    chk_bit("R5", dout_en, 1'b0);

    // R1 / R4 / R5: fill and read back every word
    for (int a = 0; a < DEPTH; a++) wr_full(AW'(a), DW'(16'hA500 ^ (a * 16'h0111)));
    for (int a = 0; a < DEPTH; a++) rd_proc(AW'(a), "R4");

    // R2 / R3: byte-enable sweep on every address
    for (int a = 0; a < DEPTH; a++) begin
      for (int v = 0; v < (1 << NB); v++) begin
        logic [DW-1:0] d = DW'(16'h3C00 + a * 16 + v);
        idle_inputs(); adsc_n = 1'b0; bwe_n = 1'b0; bw_n = NB'(v);
        addr = AW'(a); din = d;
        tick();
        if (v == (1 << NB) - 1) chk_data("R3", model[a]);
        else model[a] = merge(model[a], d, ~NB'(v));
        idle_inputs();
        rd_proc(AW'(a), "R2");
      end
    end

    // R3: master enable high overrides byte enables
    idle_inputs(); adsc_n = 1'b0; bwe_n = 1'b1; bw_n = '0; addr = 4'd6; din = 16'hDEAD;
    tick();
    chk_data("R3", model[6]);
    idle_inputs();
    rd_proc(4'd6, "R3");

    // R8 / R9: burst writes then burst reads, every start address
    for (int lm = 0; lm < 2; lm++) begin
      lin_mode = lm[0];
      for (int s = 0; s < DEPTH; s++) begin
        for (int k = 0; k < 4; k++) begin
          logic [DW-1:0] d = DW'(16'h7000 + lm * 16'h0800 + s * 16'h0010 + k);
          idle_inputs(); gw_n = 1'b0; din = d;
          if (k == 0) begin adsc_n = 1'b0; addr = AW'(s); end
          else adv_n = 1'b0;
          tick();
          model[baddr(AW'(s), k, lm[0])] = d;
        end
        idle_inputs(); adsp_n = 1'b0; addr = AW'(s);
        tick();
        chk_data(lm ? "R8" : "R9", model[s]);
        for (int k = 1; k < 4; k++) begin
          idle_inputs(); adv_n = 1'b0;
          tick();
          chk_data(lm ? "R8" : "R9", model[baddr(AW'(s), k, lm[0])]);
        end
        idle_inputs();
      end
    end
    lin_mode = 1'b1;

    // R10: hold repeats address, then advance
    rd_proc(4'd5, "R10");
    adv_n = 1'b1; tick(); chk_data("R10", model[5]);
    adv_n = 1'b0; tick(); chk_data("R10", model[6]);
    idle_inputs();

    // R12: chip select high without a strobe does not stop the burst
    rd_proc(4'd8, "R12");
    cs_n = 1'b1; adv_n = 1'b0; tick(); chk_data("R12", model[9]);
    idle_inputs();

    // R7: deselect via either select, burst ends
    rd_proc(4'd12, "R7");
    adsc_n = 1'b0; cs_n = 1'b1; addr = 4'd0; tick();
    chk_bit("R7", dout_en, 1'b0);
    idle_inputs(); adv_n = 1'b0; tick();
    chk_bit("R7", dout_en, 1'b0);
    rd_proc(4'd12, "R7");
    adsp_n = 1'b0; cs2 = 1'b0; tick();
    chk_bit("R7", dout_en, 1'b0);
    idle_inputs(); gw_n = 1'b0; adv_n = 1'b0; din = 16'hBAD0; tick();
    idle_inputs();
    rd_proc(4'd13, "R7");

    // R6: output enable acts without a clock
    rd_proc(4'd3, "R6");
    oe_n = 1'b1; #1; chk_bit("R6", dout_en, 1'b0);
    oe_n = 1'b0; #1; chk_bit("R6", dout_en, 1'b1);
    idle_inputs(); tick();

    // R11: sleep entry and exit timing, content retention
    sleep = 1'b1;
    rd_proc(4'd1, "R11");
    rd_proc(4'd2, "R11");
    adsp_n = 1'b0; addr = 4'd3; tick(); chk_bit("R11", dout_en, 1'b0);
    idle_inputs(); adsc_n = 1'b0; gw_n = 1'b0; addr = 4'd0; din = 16'h0BAD; tick();
    chk_bit("R11", dout_en, 1'b0);
    idle_inputs();
    sleep = 1'b0;
    adsp_n = 1'b0; addr = 4'd0; tick(); chk_bit("R11", dout_en, 1'b0);
    adsp_n = 1'b0; addr = 4'd0; tick(); chk_bit("R11", dout_en, 1'b0);
    rd_proc(4'd0, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule